// File: doc/BRIEF.md
# Rotated-Immediate Constant Encoder and Splitter

This block answers two questions about a 32-bit constant. The first is whether the constant can be written as one immediate. An immediate here is an 8-bit literal, zero-extended to 32 bits and then rotated right by twice a 4-bit rotate field. The query port answers this question combinationally. When the constant fits, the query port also returns the rotate field and the literal.

The second question is how to build a constant that does not fit. A start pulse hands the constant to a sequential splitter. The splitter emits a series of chunks, one per valid/ready handshake. The first chunk is marked as the initial move, and every later chunk is meant to be ORed into the result. If the constant fits in one immediate, the splitter emits that single chunk. Otherwise it covers the set bits greedily:

1. Take the lowest remaining set bit.
2. Round its position down to an even number p.
3. Emit the 8-bit window that starts at p.
4. Clear those bits from the remainder, and repeat until the remainder is zero.

The splitter raises a one-cycle done strobe after the last chunk is accepted.

Top module: `rotimm_encoder`

## Requirements
- R1: `fit_ok` is 1 exactly when some rotate field n in 0..15 makes the constant equal to the 8-bit literal rotated right by 2n. When it is 1, `fit_lit` rotated right by 2×`fit_rot` equals `fit_const`.
- R2: When several rotate fields work, `fit_rot` is the smallest of them.
- R3: 0x00000102 is reported as not fitting. 0x00000104 and 0x00000204 are reported as fitting, both with rotate field 15, with literals 0x41 and 0x81.
- R4: After a start pulse, the first chunk has `chunk_first`=1 and every later chunk has `chunk_first`=0. The OR of all chunk values equals the constant.
- R5: A split emits at most 4 chunks, and no two chunk values share a set bit.
- R6: A constant that fits one immediate is split into exactly one chunk, equal to the query answer for that constant.
- R7: A constant that does not fit is split by the greedy rule. Each window starting at even bit p is encoded with literal = (remainder rotated right by p) & 0xFF and rotate field = ((32−p) mod 32)/2.
- R8: 0x1635427C is split into exactly three chunks, in this order: 0x0000027C (rotate 15, literal 0x9F), 0x00354000 (rotate 9, literal 0xD5) and 0x16000000 (rotate 4, literal 0x16).
- R9: The constant 0 is split into one move chunk with literal 0 and rotate 0.
- R10: While `chunk_valid` is high and `chunk_ready` is low, the chunk stays valid and its fields do not change on the next cycle.
- R11: A start pulse that arrives while `split_busy` is high is ignored. The split in progress completes with the chunks of its own constant.
- R12: After reset, `split_busy`, `chunk_valid` and `split_done` are 0. `split_done` is high for exactly one cycle, in the cycle after the last chunk handshake, and `split_busy` is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fit_const | input | 32 | Constant for the single-immediate query |
| fit_ok | output | 1 | Query constant fits one immediate |
| fit_rot | output | 4 | Rotate field (rotate right by twice this value) |
| fit_lit | output | 8 | 8-bit literal |
| split_start | input | 1 | Start pulse, sampled while idle |
| split_const | input | 32 | Constant to split, captured on start |
| split_busy | output | 1 | A split is in progress |
| chunk_valid | output | 1 | A chunk is offered |
| chunk_ready | input | 1 | Consumer accepts the offered chunk |
| chunk_rot | output | 4 | Chunk rotate field |
| chunk_lit | output | 8 | Chunk literal |
| chunk_first | output | 1 | Chunk is the initial move (1) or an OR step (0) |
| split_done | output | 1 | One-cycle strobe after the last chunk is accepted |

## Verification
The embedded properties assume three things:
- Reset is applied before the first start pulse.
- `split_const` only matters in the cycle that `split_start` is sampled while idle.
- The consumer may hold `chunk_ready` low for any number of cycles.

The stimulus changes `split_const` and pulses `split_start` again in the middle of a busy split, which exercises the capture rule. It toggles `chunk_ready` from a pseudo-random sequence, and forces it high only late in a split, so stalls of one or more cycles occur at every chunk position.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
    localparam int WORD_W     = 32;
    localparam int LIT_W      = 8;
    localparam int ROT_W      = 4;
    localparam int NUM_ROT    = 1 << ROT_W;
    localparam int MAX_CHUNKS = WORD_W / LIT_W;
    localparam int CNT_W      = $clog2(MAX_CHUNKS + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic [LIT_W-1:0] lit;
    } imm_t;

    typedef struct packed {
        imm_t imm;
        logic first;
    } chunk_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_DONE
    } split_state_t;

    function automatic word_t rot_left(word_t v, int amt);
        int a;
        a = amt % WORD_W;
        if (a == 0) return v;
        return (v << a) | (v >> (WORD_W - a));
    endfunction

    function automatic word_t rot_right(word_t v, int amt);
        int a;
        a = amt % WORD_W;
        if (a == 0) return v;
        return (v >> a) | (v << (WORD_W - a));
    endfunction

    function automatic word_t imm_value(imm_t im);
        return rot_right(word_t'(im.lit), 2 * int'(im.rot));
    endfunction
endpackage

// File: rtl/rotimm_fit.sv
module rotimm_fit
    import rotimm_pkg::*;
(
    input  word_t value,
    output logic  fits,
    output imm_t  imm
);
    word_t              rolled [NUM_ROT];
    logic [NUM_ROT-1:0] ok;

    for (genvar r = 0; r < NUM_ROT; r++) begin : g_rot
        assign rolled[r] = rot_left(value, 2 * r);
        assign ok[r]     = (rolled[r][WORD_W-1:LIT_W] == '0);
    end

    // Scan from the top so the smallest working rotate is the last one written.
    always_comb begin
        fits = 1'b0;
        imm  = '0;
        for (int r = NUM_ROT - 1; r >= 0; r--) begin
            if (ok[r]) begin
                fits    = 1'b1;
                imm.rot = ROT_W'(r);
                imm.lit = rolled[r][LIT_W-1:0];
            end
        end
    end

    always_comb begin
        if (fits) begin
            p_fit_rebuild_r1: assert (imm_value(imm) == value);
        end
    end
endmodule

// File: rtl/rotimm_window.sv
module rotimm_window
    import rotimm_pkg::*;
(
    input  word_t rem,
    output imm_t  imm,
    output word_t piece,
    output word_t rest
);
    int    low_bit;
    int    pos;
    word_t mask;

    always_comb begin
        low_bit = 0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (rem[i]) low_bit = i;
        end
        pos     = low_bit & ~1;
        imm.lit = LIT_W'(rot_right(rem, pos));
        imm.rot = ROT_W'(((WORD_W - pos) % WORD_W) / 2);
        mask    = rot_left(word_t'({LIT_W{1'b1}}), pos);
        piece   = imm_value(imm);
        rest    = rem & ~mask;
    end

    always_comb begin
        p_piece_inside_r7: assert ((piece & ~rem) == '0);
        if (rem != '0) begin
            p_piece_nonzero_r7: assert (piece != '0);
        end
    end
endmodule

// File: rtl/rotimm_splitter.sv
module rotimm_splitter
    import rotimm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  word_t  value,
    output logic   busy,
    output logic   valid,
    input  logic   ready,
    output chunk_t chunk,
    output logic   done
);
    split_state_t     state_q;
    word_t            rem_q;
    logic             first_q;
    logic [CNT_W-1:0] cnt_q;

    logic  one_ok;
    imm_t  one_imm;
    imm_t  win_imm;
    word_t win_piece;
    word_t win_rest;
    logic  use_one;
    word_t next_rem;
    word_t chunk_val;

    rotimm_fit u_fit (
        .value (rem_q),
        .fits  (one_ok),
        .imm   (one_imm)
    );

    rotimm_window u_win (
        .rem   (rem_q),
        .imm   (win_imm),
        .piece (win_piece),
        .rest  (win_rest)
    );

    // A constant that fits one immediate (zero included) is sent as a single move.
    assign use_one     = first_q && one_ok;
    assign chunk.imm   = use_one ? one_imm : win_imm;
    assign chunk.first = first_q;
    assign next_rem    = use_one ? '0 : win_rest;
    assign chunk_val   = imm_value(chunk.imm);

    assign valid = (state_q == ST_EMIT);
    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            first_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rem_q   <= value;
                        first_q <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (ready) begin
                        rem_q   <= next_rem;
                        first_q <= 1'b0;
                        cnt_q   <= cnt_q + 1'b1;
                        if (next_rem == '0) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(chunk));

    p_ignore_start_r11: assert property (@(posedge clk) disable iff (rst)
        busy && !(valid && ready) |=> $stable(rem_q));

    p_max_chunks_r5: assert property (@(posedge clk) disable iff (rst)
        valid |-> cnt_q < CNT_W'(MAX_CHUNKS));

    p_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
        valid && ready |=> (rem_q & $past(chunk_val)) == '0);

    p_first_flag_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> chunk.first == (cnt_q == '0));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
endmodule

// File: rtl/rotimm_encoder.sv
module rotimm_encoder
    import rotimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fit_const,
    output logic              fit_ok,
    output logic [ROT_W-1:0]  fit_rot,
    output logic [LIT_W-1:0]  fit_lit,
    input  logic              split_start,
    input  logic [WORD_W-1:0] split_const,
    output logic              split_busy,
    output logic              chunk_valid,
    input  logic              chunk_ready,
    output logic [ROT_W-1:0]  chunk_rot,
    output logic [LIT_W-1:0]  chunk_lit,
    output logic              chunk_first,
    output logic              split_done
);
    imm_t   q_imm;
    chunk_t s_chunk;

    rotimm_fit u_query (
        .value (fit_const),
        .fits  (fit_ok),
        .imm   (q_imm)
    );

    rotimm_splitter u_split (
        .clk   (clk),
        .rst   (rst),
        .start (split_start),
        .value (split_const),
        .busy  (split_busy),
        .valid (chunk_valid),
        .ready (chunk_ready),
        .chunk (s_chunk),
        .done  (split_done)
    );

    assign fit_rot     = q_imm.rot;
    assign fit_lit     = q_imm.lit;
    assign chunk_rot   = s_chunk.imm.rot;
    assign chunk_lit   = s_chunk.imm.lit;
    assign chunk_first = s_chunk.first;
endmodule

// File: tb/sim_rotimm_encoder.sv
module sim_rotimm_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fit_const = '0;
    logic        fit_ok;
    logic [3:0]  fit_rot;
    logic [7:0]  fit_lit;
    logic        split_start = 1'b0;
    logic [31:0] split_const = '0;
    logic        split_busy;
    logic        chunk_valid;
    logic        chunk_ready = 1'b0;
    logic [3:0]  chunk_rot;
    logic [7:0]  chunk_lit;
    logic        chunk_first;
    logic        split_done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    rotimm_encoder u0 (
        .clk(clk), .rst(rst),
        .fit_const(fit_const), .fit_ok(fit_ok), .fit_rot(fit_rot), .fit_lit(fit_lit),
        .split_start(split_start), .split_const(split_const), .split_busy(split_busy),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_rot(chunk_rot), .chunk_lit(chunk_lit), .chunk_first(chunk_first),
        .split_done(split_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] ror32(logic [31:0] v, int n);
        int a;
        a = n % 32;
        if (a == 0) return v;
        return (v >> a) | (v << (32 - a));
    endfunction

    function automatic logic [31:0] nextrand(logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference: smallest n in 0..15 for which c = lit ror 2n.
    function automatic bit ref_fit(logic [31:0] c, output logic [3:0] rot, output logic [7:0] lit);
        rot = '0;
        lit = '0;
        for (int n = 0; n < 16; n++) begin
            logic [31:0] back;
            back = ror32(c, 32 - 2 * n);
            if (back[31:8] == 24'h0) begin
                rot = 4'(n);
                lit = back[7:0];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic query(logic [31:0] c);
        logic [3:0] er;
        logic [7:0] el;
        bit ef;
        @(negedge clk);
        fit_const = c;
        #1;
        ef = ref_fit(c, er, el);
        chk(fit_ok == ef, "R1", "fits", 32'(fit_ok), 32'(ef));
        if (ef && fit_ok) begin
            chk(fit_rot == er, "R2", "smallest rot", 32'(fit_rot), 32'(er));
            chk(fit_lit == el, "R1", "literal", 32'(fit_lit), 32'(el));
        end
    endtask

    task automatic run_split(logic [31:0] c, bit inject);
        logic [3:0]  erot [4];
        logic [7:0]  elit [4];
        logic [31:0] gval [4];
        logic [3:0]  grot [4];
        logic [7:0]  glit [4];
        logic        gfst [4];
        int          en = 0;
        int          got = 0;
        bit          seen_done = 1'b0;
        bit          stalled = 1'b0;
        logic [13:0] held = '0;
        logic [31:0] orv = '0;
        logic [31:0] rem;
        logic [3:0]  r1;
        logic [7:0]  l1;

        // Expected chunk list.
        if (ref_fit(c, r1, l1)) begin
            erot[0] = r1;
            elit[0] = l1;
            en = 1;
        end else begin
            rem = c;
            while (rem != 0 && en < 4) begin
                int lo = 0;
                int p;
                for (int i = 31; i >= 0; i--) if (rem[i]) lo = i;
                p = lo & ~1;
                elit[en] = ror32(rem, p)[7:0];
                erot[en] = 4'(((32 - p) % 32) / 2);
                rem = rem & ~ror32({24'h0, elit[en]}, 2 * int'(erot[en]));
                en++;
            end
        end

        @(negedge clk);
        split_const = c;
        split_start = 1'b1;
        @(negedge clk);
        split_start = 1'b0;
        split_const = ~c;
        for (int cyc = 0; cyc < 64 && !seen_done; cyc++) begin
            split_start = (inject && cyc == 1);
            if (split_done) begin
                seen_done = 1'b1;
                chunk_ready = 1'b0;
                @(negedge clk);
                split_start = 1'b0;
                chk(!split_done && !split_busy, "R12", "done one cycle then idle",
                    {30'h0, split_done, split_busy}, 32'h0);
            end else begin
                if (chunk_valid) begin
                    if (stalled)
                        chk({chunk_rot, chunk_lit, chunk_first, 1'b1} == held, "R10",
                            "held chunk", 32'({chunk_rot, chunk_lit, chunk_first}), 32'(held[13:1]));
                    lfsr = nextrand(lfsr);
                    chunk_ready = lfsr[3] | (cyc > 40);
                    if (chunk_ready) begin
                        if (got < 4) begin
                            grot[got] = chunk_rot;
                            glit[got] = chunk_lit;
                            gfst[got] = chunk_first;
                            gval[got] = ror32({24'h0, chunk_lit}, 2 * int'(chunk_rot));
                        end
                        got++;
                    end
                    stalled = !chunk_ready;
                    held = {chunk_rot, chunk_lit, chunk_first, 1'b1};
                end else begin
                    chunk_ready = 1'b0;
                    stalled = 1'b0;
                end
                @(negedge clk);
            end
        end
        chunk_ready = 1'b0;
        split_start = 1'b0;
        chk(seen_done, "R12", "done seen", 32'(seen_done), 32'h1);
        chk(got == en && got <= 4, "R5", "chunk count", 32'(got), 32'(en));
        for (int k = 0; k < got && k < 4; k++) begin
            orv = orv | gval[k];
            chk(gfst[k] == (k == 0), "R4", "first flag", 32'(gfst[k]), 32'(k == 0));
            if (k < en)
                chk(grot[k] == erot[k] && glit[k] == elit[k], "R7", "chunk encoding",
                    {20'h0, grot[k], glit[k]}, {20'h0, erot[k], elit[k]});
            for (int j = 0; j < k; j++)
                chk((gval[j] & gval[k]) == 0, "R5", "disjoint", gval[j] & gval[k], 32'h0);
        end
        chk(orv == c, "R4", "OR of chunks", orv, c);
        if (en == 1) chk(got == 1, "R6", "single chunk", 32'(got), 32'h1);
        if (c == 32'h1635_427C && got == 3) begin
            chk(gval[0] == 32'h0000_027C, "R8", "chunk0", gval[0], 32'h0000_027C);
            chk(gval[1] == 32'h0035_4000, "R8", "chunk1", gval[1], 32'h0035_4000);
            chk(gval[2] == 32'h1600_0000, "R8", "chunk2", gval[2], 32'h1600_0000);
        end
        if (c == 32'h0 && got == 1)
            chk(glit[0] == 8'h0 && grot[0] == 4'h0 && gfst[0], "R9", "zero move",
                {19'h0, grot[0], glit[0], gfst[0]}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!split_busy && !chunk_valid && !split_done, "R12", "reset state",
            {29'h0, split_busy, chunk_valid, split_done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!split_busy && !chunk_valid && !split_done, "R12", "idle after reset",
            {29'h0, split_busy, chunk_valid, split_done}, 32'h0);

        // R3 named cases
        @(negedge clk);
        fit_const = 32'h102;
        #1 chk(!fit_ok, "R3", "0x102 not fit", 32'(fit_ok), 32'h0);
        @(negedge clk);
        fit_const = 32'h104;
        #1 chk(fit_ok && fit_rot == 4'd15 && fit_lit == 8'h41, "R3", "0x104",
               {19'h0, fit_ok, fit_rot, fit_lit}, {19'h0, 1'b1, 4'd15, 8'h41});
        @(negedge clk);
        fit_const = 32'h204;
        #1 chk(fit_ok && fit_rot == 4'd15 && fit_lit == 8'h81, "R3", "0x204",
               {19'h0, fit_ok, fit_rot, fit_lit}, {19'h0, 1'b1, 4'd15, 8'h81});

        // R1/R2 sweep: every literal at every rotation amount, odd ones included.
        for (int l = 0; l < 256; l++)
            for (int s = 0; s < 32; s++)
                query(ror32(32'(l), s));
        for (int k = 0; k < 1500; k++) begin
            lfsr = nextrand(lfsr);
            query(lfsr);
        end

        // Split cases
        run_split(32'h1635_427C, 1'b0);
        run_split(32'h0, 1'b0);
        run_split(32'hF000_000F, 1'b0);
        run_split(32'hFFFF_FFFF, 1'b0);
        run_split(32'h8000_0001, 1'b0);
        run_split(32'h0000_0102, 1'b0);
        run_split(32'h1635_427C, 1'b1);  // R11 start during busy
        run_split(32'h0000_00FF, 1'b1);  // R11 with a single chunk
        for (int k = 0; k < 300; k++) begin
            logic [31:0] v;
            lfsr = nextrand(lfsr);
            v = lfsr;
            lfsr = nextrand(lfsr);
            if (lfsr[1:0] == 2'b00) v = v & lfsr;
            run_split(v, k[0]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule